// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. While armed, an internal tick counter advances once per clock. Two compare values are held in registers. The first, the warning threshold, raises a level interrupt so that software can react before the system is reset. The second, the expiry threshold, produces a one-cycle reset request for the chip's reset controller. Software keeps the system alive by writing the restart register before the expiry threshold is reached. That write returns the counter to zero and withdraws any pending warning.

A sticky flag records that an expiry reset request was issued. Only the power-on reset input clears it, or software writing a one to it. Software can therefore tell, after the system restarts, that the watchdog caused the reset. Thresholds are counts of input clock ticks. Software usually computes the warning value as (timeout − warning lead) × tick rate and the expiry value as timeout × tick rate. Two register address layouts exist, and a parameter selects one at build time.

Top module: `dual_stage_wdog`

## Requirements
- R1: After power-on reset, the control register reads 0, the status register reads 0, both thresholds read 0x10000000, the restart register reads 0, and both the interrupt and the reset request are low.
- R2: With LAYOUT_ALT=0 the restart, control, status, warning-threshold and expiry-threshold registers sit at 0x04, 0x08, 0x0C, 0x10 and 0x14. With LAYOUT_ALT=1 they sit at 0x38, 0x40, 0x44, 0x4C and 0x5C. Any other address reads 0 and writes to it change nothing. Read data appears on bus_rdata in the cycle after the clock edge that samples bus_rd.
- R3: Control register bit 0 arms the counter and bit 1 enables the warning interrupt. Both bits read back as written, and the other bits read 0.
- R4: If the control write that arms the counter is sampled at clock edge 0, bite_req is high exactly in the cycle after edge T+1, where T is the expiry threshold.
- R5: With the interrupt enabled and warning threshold B below T, bark_irq rises in the cycle after edge B+1. It then stays high until a restart, a disarm, or an interrupt-disable write.
- R6: With control bit 1 clear, bark_irq never rises.
- R7: When B is greater than or equal to T, bark_irq never rises.
- R8: After the expiry pulse the counter holds, and no further reset request comes until a restart or a disarm.
- R9: Writing restart bit 0 as 1 at edge E clears bark_irq from the next cycle and restarts the count, so the expiry pulse follows T+1 edges after E. Writing 0 to the restart register has no effect.
- R10: Writing control bit 0 as 0 stops the watchdog at once. bark_irq drops, no reset request follows, and the next arm counts from zero.
- R11: Status bit 0 is set one cycle after the reset request pulse. Disarming and restarting do not clear it, and neither does writing 0 to it. Writing 1 to status bit 0 clears it.
- R12: A threshold write larger than 0x10000000 is stored as 0x10000000, and smaller values are stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the tick source |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bark_irq | output | 1 | Warning interrupt, level |
| bite_req | output | 1 | Reset request, single-cycle pulse |

## Verification
Random warning/expiry threshold pairs are drawn with the interrupt enable on or off, so one pattern set covers both orderings. It separates pairs where B<T, where the interrupt appears at B+1, from pairs where B≥T, where it must stay silent, and separates enabled runs from masked ones. Directed runs hold the count long past expiry to separate a single saturating pulse from a repeating one. They insert restart writes of 0 and 1 mid-count to show that only a set bit reloads. They disarm mid-count and then re-arm to show that the count restarts at zero. A second instance on the other layout gets the same writes, which shows that each decoder answers only at its own offsets.

// File: rtl/dual_stage_wdog_pkg.sv
package dual_stage_wdog_pkg;

    localparam int unsigned WD_CNT_W   = 29;
    localparam logic [31:0] WD_THR_MAX = 32'h1000_0000;

    typedef logic [WD_CNT_W-1:0] wd_cnt_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RESTART,
        SEL_CTRL,
        SEL_STATUS,
        SEL_WARN,
        SEL_EXPIRE
    } wd_sel_e;

    typedef struct packed {
        logic    run;
        logic    irq_en;
        logic    restart;
        logic    halt;
        logic    irq_off;
        wd_cnt_t warn_thr;
        wd_cnt_t expire_thr;
    } wd_ctl_t;

    typedef struct packed {
        logic warn_hit;
        logic expire_hit;
    } wd_match_t;

    function automatic logic [31:0] wd_offset(input bit alt, input wd_sel_e sel);
        logic [31:0] off;
        off = 32'hFFFF_FFFF;
        case (sel)
            SEL_RESTART: off = alt ? 32'h38 : 32'h04;
            SEL_CTRL:    off = alt ? 32'h40 : 32'h08;
            SEL_STATUS:  off = alt ? 32'h44 : 32'h0C;
            SEL_WARN:    off = alt ? 32'h4C : 32'h10;
            SEL_EXPIRE:  off = alt ? 32'h5C : 32'h14;
            default:     off = 32'hFFFF_FFFF;
        endcase
        return off;
    endfunction

    function automatic wd_sel_e wd_decode(input bit alt, input logic [31:0] addr);
        wd_sel_e sel;
        sel = SEL_NONE;
        if (addr == wd_offset(alt, SEL_RESTART)) sel = SEL_RESTART;
        if (addr == wd_offset(alt, SEL_CTRL))    sel = SEL_CTRL;
        if (addr == wd_offset(alt, SEL_STATUS))  sel = SEL_STATUS;
        if (addr == wd_offset(alt, SEL_WARN))    sel = SEL_WARN;
        if (addr == wd_offset(alt, SEL_EXPIRE))  sel = SEL_EXPIRE;
        return sel;
    endfunction

    function automatic wd_cnt_t wd_clamp(input logic [31:0] v);
        logic [31:0] c;
        c = (v > WD_THR_MAX) ? WD_THR_MAX : v;
        return c[WD_CNT_W-1:0];
    endfunction

    function automatic logic [31:0] wd_widen(input wd_cnt_t v);
        return {{(32-WD_CNT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import dual_stage_wdog_pkg::*;
#(
    parameter bit          LAYOUT_ALT = 1'b0,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              expire_evt,
    output logic [31:0]       rdata,
    output wd_ctl_t           ctl
);

    localparam wd_cnt_t THR_RESET = wd_clamp(WD_THR_MAX);

    wd_sel_e sel;
    logic    run_q, irq_en_q, sts_q, sts_clr_p;
    wd_cnt_t warn_q, expire_q;

    always_comb begin
        sel       = wd_decode(LAYOUT_ALT, 32'(addr));
        sts_clr_p = wr && (sel == SEL_STATUS) && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            irq_en_q <= 1'b0;
            warn_q   <= THR_RESET;
            expire_q <= THR_RESET;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: begin
                    run_q    <= wdata[0];
                    irq_en_q <= wdata[1];
                end
                SEL_WARN:   warn_q   <= wd_clamp(wdata);
                SEL_EXPIRE: expire_q <= wd_clamp(wdata);
                default: ;
            endcase
        end
    end

    // sticky expiry flag: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst)             sts_q <= 1'b0;
        else if (expire_evt) sts_q <= 1'b1;
        else if (sts_clr_p)  sts_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                SEL_CTRL:   rdata <= {30'd0, irq_en_q, run_q};
                SEL_STATUS: rdata <= {31'd0, sts_q};
                SEL_WARN:   rdata <= wd_widen(warn_q);
                SEL_EXPIRE: rdata <= wd_widen(expire_q);
                default:    rdata <= '0;
            endcase
        end
    end

    always_comb begin
        ctl            = '0;
        ctl.run        = run_q;
        ctl.irq_en     = irq_en_q;
        ctl.restart    = wr && (sel == SEL_RESTART) && wdata[0];
        ctl.halt       = wr && (sel == SEL_CTRL) && !wdata[0];
        ctl.irq_off    = wr && (sel == SEL_CTRL) && !wdata[1];
        ctl.warn_thr   = warn_q;
        ctl.expire_thr = expire_q;
    end

endmodule

// File: rtl/wdog_cmp.sv
module wdog_cmp
    import dual_stage_wdog_pkg::*;
(
    input  wd_cnt_t   count,
    input  logic      spent,
    input  wd_ctl_t   ctl,
    output wd_match_t m
);

    logic live;

    always_comb begin
        live         = ctl.run && !spent;
        m.expire_hit = live && (count == ctl.expire_thr);
        m.warn_hit   = live && (ctl.warn_thr < ctl.expire_thr)
                            && (count == ctl.warn_thr);
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import dual_stage_wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_ctl_t ctl,
    output logic    warn_lvl,
    output logic    expire_pulse
);

    wd_cnt_t   count_q;
    logic      spent_q;
    wd_match_t m;

    wdog_cmp u_cmp (
        .count (count_q),
        .spent (spent_q),
        .ctl   (ctl),
        .m     (m)
    );

    always_ff @(posedge clk) begin
        if (rst || ctl.restart || ctl.halt) begin
            count_q      <= '0;
            spent_q      <= 1'b0;
            warn_lvl     <= 1'b0;
            expire_pulse <= 1'b0;
        end else begin
            expire_pulse <= m.expire_hit;
            if (!ctl.run) begin
                count_q <= '0;
                spent_q <= 1'b0;
            end else if (m.expire_hit) begin
                spent_q <= 1'b1;
            end else if (!spent_q) begin
                count_q <= count_q + 1'b1;
            end
            if (ctl.irq_off)
                warn_lvl <= 1'b0;
            else if (m.warn_hit && ctl.irq_en)
                warn_lvl <= 1'b1;
        end
    end

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
    import dual_stage_wdog_pkg::*;
#(
    parameter bit          LAYOUT_ALT = 1'b0,
    parameter int unsigned ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bark_irq,
    output logic              bite_req
);

    wd_ctl_t ctl;

    wdog_regfile #(
        .LAYOUT_ALT (LAYOUT_ALT),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .expire_evt (bite_req),
        .rdata      (bus_rdata),
        .ctl        (ctl)
    );

    wdog_core u_core (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl),
        .warn_lvl     (bark_irq),
        .expire_pulse (bite_req)
    );

endmodule

// File: rtl/dual_stage_wdog_checker.sv
module dual_stage_wdog_checker (
    input logic clk,
    input logic rst,
    input logic run,
    input logic irq_en,
    input logic restart,
    input logic sts,
    input logic sts_clr,
    input logic bark_irq,
    input logic bite_req
);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        bite_req |=> !bite_req);

    assert_status_set_R11: assert property (@(posedge clk) disable iff (rst)
        bite_req |=> sts);

    assert_status_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (sts && !sts_clr) |=> sts);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !bark_irq);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!bark_irq && !bite_req));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!bark_irq && !bite_req));

endmodule

bind dual_stage_wdog dual_stage_wdog_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.run),
    .irq_en   (ctl.irq_en),
    .restart  (ctl.restart),
    .sts      (u_regs.sts_q),
    .sts_clr  (u_regs.sts_clr_p),
    .bark_irq (bark_irq),
    .bite_req (bite_req)
);

// File: tb/dual_stage_wdog_tb.sv
module dual_stage_wdog_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          WD_LIMIT   = 150000;
    localparam logic [7:0]  A_RST  = 8'h04, A_CTL = 8'h08, A_STS = 8'h0C,
                            A_WARN = 8'h10, A_EXP = 8'h14;
    localparam logic [7:0]  A_ALT_WARN = 8'h4C;
    localparam logic [31:0] THR_MAX = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic        irq, bite, irq_alt, bite_alt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_stage_wdog #(.LAYOUT_ALT(1'b0), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .bark_irq(irq), .bite_req(bite));

    dual_stage_wdog #(.LAYOUT_ALT(1'b1), .ADDR_W(8)) dut_alt_i (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_alt), .bark_irq(irq_alt), .bite_req(bite_alt));

    function automatic logic exp_bite(int n, int t);
        return n == t + 1;
    endfunction

    function automatic logic exp_irq(int n, int b, int t, logic ie);
        return ie && (b < t) && (n >= b + 1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        rd = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
    endtask

    task automatic rd_reg(logic [7:0] a);
        rd = 1'b1; addr = a;
        cyc();
    endtask

    task automatic run_window(int b, int t, logic ie, int n_first, int n_last, string irq_tag);
        for (int n = n_first; n <= n_last; n++) begin
            cyc();
            chk(irq_tag, {31'd0, irq}, {31'd0, exp_irq(n, b, t, ie)});
            chk("R4 bite timing", {31'd0, bite}, {31'd0, exp_bite(n, t)});
        end
    endtask

    task automatic trial(int b, int t, logic ie);
        string tag;
        tag = !ie ? "R6 masked irq" : (b >= t ? "R7 no early irq" : "R5 irq timing");
        wr_reg(A_WARN, b);
        wr_reg(A_EXP, t);
        wr_reg(A_CTL, {30'd0, ie, 1'b1});
        run_window(b, t, ie, 1, t + 4, tag);
        wr_reg(A_CTL, 32'd0);
        chk("R10 disarm drops irq", {31'd0, irq}, 32'd0);
        rd_reg(A_STS);
        chk("R11 status after bite", rdata, 32'd1);
        wr_reg(A_STS, 32'd1);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2718);
        repeat (3) cyc();
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 bite", {31'd0, bite}, 32'd0);
        rd_reg(A_CTL);  chk("R1 ctrl", rdata, 32'd0);
        rd_reg(A_STS);  chk("R1 status", rdata, 32'd0);
        rd_reg(A_WARN); chk("R1 warn thr", rdata, THR_MAX);
        rd_reg(A_EXP);  chk("R1 expire thr", rdata, THR_MAX);
        rd_reg(A_RST);  chk("R1 restart reads 0", rdata, 32'd0);

        // R12 clamping
        wr_reg(A_EXP, 32'hFFFF_FFFF);
        rd_reg(A_EXP);  chk("R12 clamp high", rdata, THR_MAX);
        wr_reg(A_WARN, 32'h0FFF_FFFF);
        rd_reg(A_WARN); chk("R12 below max kept", rdata, 32'h0FFF_FFFF);
        wr_reg(A_EXP, 32'h1000_0001);
        rd_reg(A_EXP);  chk("R12 max+1 clamped", rdata, THR_MAX);

        // R2 layouts and unmapped space
        wr_reg(A_WARN, 32'h55);
        wr_reg(A_ALT_WARN, 32'h66);
        wr_reg(8'h20, 32'hFFFF_FFFF);
        rd_reg(A_WARN);
        chk("R2 main warn", rdata, 32'h55);
        chk("R2 alt ignores 0x10", rdata_alt, 32'd0);
        rd_reg(A_ALT_WARN);
        chk("R2 main ignores 0x4C", rdata, 32'd0);
        chk("R2 alt warn", rdata_alt, 32'h66);
        rd_reg(8'h20);  chk("R2 unmapped read", rdata, 32'd0);
        rd_reg(A_CTL);  chk("R2 unmapped write no effect", rdata, 32'd0);

        // R3 control readback, R10 nothing while unarmed
        wr_reg(A_CTL, 32'h2);
        rd_reg(A_CTL);  chk("R3 ctrl readback irq only", rdata, 32'h2);
        repeat (120) cyc();
        chk("R10 unarmed irq", {31'd0, irq}, 32'd0);
        rd_reg(A_STS);  chk("R10 unarmed no bite", rdata, 32'd0);
        wr_reg(A_CTL, 32'hFFFF_FFFF);
        rd_reg(A_CTL);  chk("R3 ctrl upper bits read 0", rdata, 32'h3);
        wr_reg(A_CTL, 32'd0);
        rd_reg(A_CTL);  chk("R3 ctrl cleared", rdata, 32'd0);

        // directed corners
        trial(0, 0, 1'b1);
        trial(0, 1, 1'b1);
        trial(5, 5, 1'b1);
        trial(10, 3, 1'b1);
        trial(6, 12, 1'b0);

        // random mix
        for (int i = 0; i < 30; i++) begin
            int b, t;
            logic ie;
            b  = int'($urandom_range(0, 40));
            t  = int'($urandom_range(0, 40));
            ie = 1'($urandom_range(0, 1));
            trial(b, t, ie);
        end

        // R8 saturation: long hold after expiry, only one pulse
        wr_reg(A_WARN, 32'd4);
        wr_reg(A_EXP, 32'd8);
        wr_reg(A_CTL, 32'd3);
        run_window(4, 8, 1'b1, 1, 80, "R8 irq held after expiry");
        wr_reg(A_CTL, 32'd0);
        wr_reg(A_STS, 32'd1);

        // R9 restart behaviour
        wr_reg(A_WARN, 32'd10);
        wr_reg(A_EXP, 32'd30);
        wr_reg(A_CTL, 32'd3);
        run_window(10, 30, 1'b1, 1, 15, "R5 irq before restart");
        wr = 1'b1; addr = A_RST; wdata = 32'd0;
        run_window(10, 30, 1'b1, 16, 20, "R9 restart of 0 ignored");
        wr_reg(A_RST, 32'd1);
        chk("R9 restart drops irq", {31'd0, irq}, 32'd0);
        run_window(10, 30, 1'b1, 1, 45, "R9 recount after restart");
        wr_reg(A_RST, 32'd1);
        chk("R9 restart after expiry drops irq", {31'd0, irq}, 32'd0);
        run_window(10, 30, 1'b1, 1, 35, "R9 rearm after saturation");

        // R11 status stickiness
        wr_reg(A_CTL, 32'd0);
        rd_reg(A_STS);  chk("R11 survives disarm", rdata, 32'd1);
        wr_reg(A_STS, 32'd0);
        rd_reg(A_STS);  chk("R11 write 0 keeps", rdata, 32'd1);
        wr_reg(A_RST, 32'd1);
        rd_reg(A_STS);  chk("R11 survives restart", rdata, 32'd1);
        wr_reg(A_STS, 32'd1);
        rd_reg(A_STS);  chk("R11 write 1 clears", rdata, 32'd0);

        // R10 disarm mid-count, then re-arm counts from zero
        wr_reg(A_WARN, 32'd3);
        wr_reg(A_EXP, 32'd12);
        wr_reg(A_CTL, 32'd3);
        run_window(3, 12, 1'b1, 1, 6, "R5 irq before disarm");
        wr_reg(A_CTL, 32'd0);
        chk("R10 disarm drops irq", {31'd0, irq}, 32'd0);
        for (int k = 0; k < 30; k++) begin
            cyc();
            chk("R10 quiet irq", {31'd0, irq}, 32'd0);
            chk("R10 quiet bite", {31'd0, bite}, 32'd0);
        end
        rd_reg(A_STS);  chk("R10 no bite after disarm", rdata, 32'd0);
        wr_reg(A_CTL, 32'd3);
        run_window(3, 12, 1'b1, 1, 16, "R10 rearm from zero");
        wr_reg(A_CTL, 32'd0);
        wr_reg(A_STS, 32'd1);

        // interrupt-disable write while armed: irq drops, count continues
        wr_reg(A_WARN, 32'd2);
        wr_reg(A_EXP, 32'd20);
        wr_reg(A_CTL, 32'd3);
        run_window(2, 20, 1'b1, 1, 5, "R5 irq before mask");
        wr_reg(A_CTL, 32'd1);
        chk("R5 irq off write drops irq", {31'd0, irq}, 32'd0);
        for (int n = 7; n <= 24; n++) begin
            cyc();
            chk("R6 irq stays masked", {31'd0, irq}, 32'd0);
            chk("R4 bite unaffected by mask", {31'd0, bite}, {31'd0, exp_bite(n, 20)});
        end
        wr_reg(A_CTL, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule